// File: doc/BRIEF.md
# Digest Output Formatter

This block presents a finished hash digest in two forms at once. The digest arrives as a 1344-bit value with its first byte in the top bits, along with a one-cycle completion strobe, the algorithm code and, for the extendable-output variants, a requested length in bytes. One cycle later the block shows the digest on a wide parallel port with a single-cycle valid pulse. In the same cycle it starts a 64-bit stream that carries only the digest bytes that are valid. Each stream word has a byte-enable mask, and the final word is flagged.

The number of valid bytes follows from the algorithm code. Codes 0 to 3 select fixed lengths. Codes 4 and 5 take the requested length, clamped to one rate block of 168 or 136 bytes. The unused codes 6 and 7 fall back to 32 bytes. The stream receiver can stall the output at any word. The block drops its input-side ready flag when the input side reports that a message has been fully taken in. It raises the flag again once the last stream word has been accepted, so the next message can begin.

Top module: `digest_out_fmt`

## Requirements
- R1: The digest length is 28, 32, 48 or 64 bytes for algorithm codes 0, 1, 2 and 3 respectively.
- R2: For code 4 the length is the requested byte count clamped to 168, and for code 5 it is clamped to 136. A request of zero gives one byte.
- R3: One cycle after a completion strobe is taken, the parallel valid is high for exactly one cycle. The parallel data then holds the digest with bytes 0 to length-1 unchanged and every later byte zero. Byte p lies at bits [1343-8p -: 8].
- R4: Stream valid rises in the same cycle as the parallel valid, with the first word presented. Digest byte p is carried in word p/8 at bits [8*(p%8) +: 8].
- R5: Every word except the final one has a byte-enable of all ones. The final word enables only the low (length - 8*(words-1)) bytes. Lanes that are not enabled carry zero.
- R6: The last flag is high on the final word only, and it is low whenever stream valid is low.
- R7: While stream valid is high and stream ready is low, the word, its enables and its last flag stay unchanged in the next cycle.
- R8: Input ready is high after reset. It is low in the cycle after a launch strobe, and it is high again in the cycle after the final word is accepted.
- R9: A completion strobe that arrives while a stream is in progress is ignored. It causes no parallel pulse and no change to the words being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Input side has accepted the final message word |
| in_ready_o | output | 1 | Input side may start a new message |
| done_i | input | 1 | Digest complete strobe |
| digest_i | input | 1344 | Digest, first byte in the top bits |
| alg_i | input | 3 | Algorithm code |
| req_len_i | input | 32 | Requested output length in bytes (codes 4 and 5) |
| par_valid_o | output | 1 | One-cycle parallel valid pulse |
| par_data_o | output | 1344 | Digest, trimmed to its length |
| st_ready_i | input | 1 | Stream receiver ready |
| st_valid_o | output | 1 | Stream word valid |
| st_data_o | output | 64 | Stream word |
| st_keep_o | output | 8 | Stream byte enables |
| st_last_o | output | 1 | Final stream word |

## Verification
Inputs change on the falling edge and results are sampled on the next falling edge, so each sample reflects exactly one rising edge. A launch strobe is followed one sample later by input ready low. A completion strobe is followed one sample later by the parallel pulse, the trimmed parallel data and the first stream word. After that, each sample is compared with the word whose index equals the number of beats accepted so far, and stalled cycles must show the same word again. One sample after the final beat is accepted, input ready is checked high and stream valid low, and a strobe injected mid-stream must leave both the pulse and the word sequence untouched.

// File: rtl/dof_pkg.sv
package dof_pkg;

  typedef enum logic [2:0] {
    ALG_FIX224 = 3'd0,
    ALG_FIX256 = 3'd1,
    ALG_FIX384 = 3'd2,
    ALG_FIX512 = 3'd3,
    ALG_XOF128 = 3'd4,
    ALG_XOF256 = 3'd5
  } alg_e;

  // Clamp a requested byte count into [1, cap].
  function automatic int unsigned clamp_len(input logic [31:0] req, input int unsigned cap);
    if (req == 32'd0) return 1;
    if (req > cap) return cap;
    return int'(req);
  endfunction

  // Byte index of lane `lane` of word `word` in a stream of `lanes` bytes per word.
  function automatic int unsigned byte_pos(input int unsigned word, input int unsigned lanes,
                                           input int unsigned lane);
    return word * lanes + lane;
  endfunction

  // Top bit of byte `p` in a digest of `width` bits, first byte topmost.
  function automatic int unsigned byte_msb(input int unsigned width, input int unsigned p);
    return width - 1 - 8 * p;
  endfunction

endpackage

// File: rtl/dof_len.sv
module dof_len #(
  parameter int LEN_W     = 32,
  parameter int CNT_W     = 8,
  parameter int RATE_X128 = 168,
  parameter int RATE_X256 = 136
) (
  input  logic [2:0]       alg_i,
  input  logic [LEN_W-1:0] req_i,
  output logic [CNT_W-1:0] nbytes_o
);
  import dof_pkg::*;

  logic [31:0] req32;
  assign req32 = 32'(req_i);

  always_comb begin
    unique case (alg_i)
      ALG_FIX224: nbytes_o = CNT_W'(28);
      ALG_FIX256: nbytes_o = CNT_W'(32);
      ALG_FIX384: nbytes_o = CNT_W'(48);
      ALG_FIX512: nbytes_o = CNT_W'(64);
      ALG_XOF128: nbytes_o = CNT_W'(clamp_len(req32, RATE_X128));
      ALG_XOF256: nbytes_o = CNT_W'(clamp_len(req32, RATE_X256));
      default:    nbytes_o = CNT_W'(32);
    endcase
  end
endmodule

// File: rtl/dof_parallel.sv
module dof_parallel #(
  parameter int DIG_W = 1344,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIG_W-1:0] digest_i,
  input  logic [CNT_W-1:0] nbytes_i,
  output logic             par_valid_o,
  output logic [DIG_W-1:0] par_data_o
);
  import dof_pkg::*;
  localparam int NBYTES = DIG_W / 8;

  logic [DIG_W-1:0] trimmed;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int MSB = byte_msb(DIG_W, b);
    assign trimmed[MSB -: 8] = (CNT_W'(b) < nbytes_i) ? digest_i[MSB -: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_valid_o <= 1'b0;
      par_data_o  <= '0;
    end else begin
      par_valid_o <= load_i;
      if (load_i) par_data_o <= trimmed;
    end
  end
endmodule

// File: rtl/dof_stream.sv
module dof_stream #(
  parameter int DIG_W = 1344,
  parameter int BUS_W = 64,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [CNT_W-1:0]   nbytes_i,
  input  logic [DIG_W-1:0]   dig_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [BUS_W-1:0]   data_o,
  output logic [BUS_W/8-1:0] keep_o,
  output logic               last_o,
  output logic               fire_o,
  output logic               finish_o
);
  import dof_pkg::*;
  localparam int LANES = BUS_W / 8;
  localparam int WORDS = DIG_W / BUS_W;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic             act;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] rem;
  logic [7:0]       lane_b [LANES];

  assign last_idx = (n_q - CNT_W'(1)) / CNT_W'(LANES);
  assign rem      = n_q - CNT_W'(idx) * CNT_W'(LANES);
  assign valid_o  = act;
  assign last_o   = act && (CNT_W'(idx) == last_idx);
  assign fire_o   = act && ready_i;
  assign finish_o = fire_o && last_o;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign keep_o[j] = act && (CNT_W'(j) < rem);
    always_comb begin
      if (keep_o[j])
        lane_b[j] = dig_i[byte_msb(DIG_W, byte_pos(int'(idx), LANES, j)) -: 8];
      else
        lane_b[j] = 8'h00;
    end
  end

  always_comb begin
    data_o = '0;
    for (int j = 0; j < LANES; j++) data_o[8*j +: 8] = lane_b[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      idx <= '0;
      n_q <= '0;
    end else if (load_i) begin
      act <= 1'b1;
      idx <= '0;
      n_q <= nbytes_i;
    end else if (fire_o) begin
      if (last_o) act <= 1'b0;
      else        idx <= idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/digest_out_fmt.sv
module digest_out_fmt #(
  parameter int DIG_W     = 1344,
  parameter int BUS_W     = 64,
  parameter int LEN_W     = 32,
  parameter int RATE_X128 = 168,
  parameter int RATE_X256 = 136
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch_i,
  output logic               in_ready_o,
  input  logic               done_i,
  input  logic [DIG_W-1:0]   digest_i,
  input  logic [2:0]         alg_i,
  input  logic [LEN_W-1:0]   req_len_i,
  output logic               par_valid_o,
  output logic [DIG_W-1:0]   par_data_o,
  input  logic               st_ready_i,
  output logic               st_valid_o,
  output logic [BUS_W-1:0]   st_data_o,
  output logic [BUS_W/8-1:0] st_keep_o,
  output logic               st_last_o
);
  localparam int DIG_BYTES = DIG_W / 8;
  localparam int CNT_W     = $clog2(DIG_BYTES + 1);

  logic [CNT_W-1:0] nbytes;
  logic             done_ok;
  logic             st_fire;
  logic             st_finish;

  assign done_ok = done_i && !st_valid_o;

  dof_len #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .RATE_X128(RATE_X128), .RATE_X256(RATE_X256)
  ) u_len (
    .alg_i(alg_i), .req_i(req_len_i), .nbytes_o(nbytes)
  );

  dof_parallel #(.DIG_W(DIG_W), .CNT_W(CNT_W)) u_par (
    .clk(clk), .rst_n(rst_n), .load_i(done_ok), .digest_i(digest_i),
    .nbytes_i(nbytes), .par_valid_o(par_valid_o), .par_data_o(par_data_o)
  );

  dof_stream #(.DIG_W(DIG_W), .BUS_W(BUS_W), .CNT_W(CNT_W)) u_st (
    .clk(clk), .rst_n(rst_n), .load_i(done_ok), .nbytes_i(nbytes),
    .dig_i(par_data_o), .ready_i(st_ready_i), .valid_o(st_valid_o),
    .data_o(st_data_o), .keep_o(st_keep_o), .last_o(st_last_o),
    .fire_o(st_fire), .finish_o(st_finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          in_ready_o <= 1'b1;
    else if (launch_i)   in_ready_o <= 1'b0;
    else if (st_finish)  in_ready_o <= 1'b1;
  end
endmodule

// File: rtl/dof_chk.sv
module dof_chk #(
  parameter int BUS_W = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               launch_i,
  input logic               in_ready_o,
  input logic               done_i,
  input logic               par_valid_o,
  input logic               st_ready_i,
  input logic               st_valid_o,
  input logic [BUS_W-1:0]   st_data_o,
  input logic [BUS_W/8-1:0] st_keep_o,
  input logic               st_last_o,
  input logic               st_finish
);
  localparam int KW = BUS_W / 8;

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid_o |=> !par_valid_o);

  assert_first_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid_o |-> st_valid_o);

  assert_keep_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid_o && !st_last_o) |-> (st_keep_o == {KW{1'b1}}));

  assert_keep_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid_o && st_last_o) |->
      (st_keep_o != '0) && ((st_keep_o & (st_keep_o + KW'(1))) == '0));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid_o |-> (!st_last_o && st_keep_o == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid_o && !st_ready_i) |=>
      (st_valid_o && $stable(st_data_o) && $stable(st_keep_o) && $stable(st_last_o)));

  assert_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> !in_ready_o);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_finish && !launch_i) |=> in_ready_o);

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid_o && done_i) |=> !par_valid_o);
endmodule

bind digest_out_fmt dof_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .in_ready_o(in_ready_o),
  .done_i(done_i), .par_valid_o(par_valid_o), .st_ready_i(st_ready_i),
  .st_valid_o(st_valid_o), .st_data_o(st_data_o), .st_keep_o(st_keep_o),
  .st_last_o(st_last_o), .st_finish(st_finish)
);

// File: tb/digest_out_fmt_tb.sv
`timescale 1ns/1ps
module digest_out_fmt_tb;
  localparam int DW = 1344;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          launch = 1'b0;
  logic          done = 1'b0;
  logic [DW-1:0] digest = '0;
  logic [2:0]    alg = 3'd0;
  logic [31:0]   req = 32'd0;
  logic          st_ready = 1'b0;
  logic          in_ready, par_valid, st_valid, st_last;
  logic [DW-1:0] par_data;
  logic [63:0]   st_data;
  logic [7:0]    st_keep;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  digest_out_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .in_ready_o(in_ready),
    .done_i(done), .digest_i(digest), .alg_i(alg), .req_len_i(req),
    .par_valid_o(par_valid), .par_data_o(par_data), .st_ready_i(st_ready),
    .st_valid_o(st_valid), .st_data_o(st_data), .st_keep_o(st_keep),
    .st_last_o(st_last)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] got,
                     input logic [DW-1:0] want);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, want);
    end
  endtask

  function automatic logic [7:0] pat(input int p, input int seed);
    return 8'((p * 73 + seed * 19 + 5) ^ (p >> 1));
  endfunction

  function automatic logic [DW-1:0] make_dig(input int seed);
    logic [DW-1:0] d = '0;
    for (int p = 0; p < DW / 8; p++) d[DW-1-8*p -: 8] = pat(p, seed);
    return d;
  endfunction

  // Expected length, restated from R1 and R2.
  function automatic int want_len(input int code, input int r);
    int cap;
    case (code)
      0: return 28;
      1: return 32;
      2: return 48;
      3: return 64;
      default: begin
        cap = (code == 4) ? 168 : 136;
        if (r == 0) return 1;
        return (r < cap) ? r : cap;
      end
    endcase
  endfunction

  // One stream job; stall=1 drops ready on some cycles, inject=1 pulses done mid-stream.
  task automatic run_job(input string tag, input int code, input int r, input int seed,
                         input bit stall, input bit inject);
    int n = want_len(code, r);
    int nw = (n + 7) / 8;
    int b = 0;
    int c = 0;
    logic [DW-1:0] d = make_dig(seed);
    logic [DW-1:0] pexp = '0;
    for (int p = 0; p < n; p++) pexp[DW-1-8*p -: 8] = d[DW-1-8*p -: 8];

    @(negedge clk); launch = 1'b1;
    @(negedge clk); launch = 1'b0;
    chk(in_ready == 1'b0, {tag, " R8 ready low after launch"}, DW'(in_ready), '0);
    alg = 3'(code); req = 32'(r); digest = d; done = 1'b1;
    @(negedge clk); done = 1'b0; digest = '0;
    chk(par_valid == 1'b1, {tag, " R3 parallel pulse"}, DW'(par_valid), DW'(1));
    chk(par_data == pexp, {tag, " R1 R2 R3 parallel trimmed data"}, par_data, pexp);
    chk(st_valid == 1'b1, {tag, " R4 first word with pulse"}, DW'(st_valid), DW'(1));

    while (b < nw && c < 400) begin
      logic [63:0] wexp = '0;
      logic [7:0]  kexp = '0;
      logic        rdy;
      for (int j = 0; j < 8; j++) begin
        if (8 * b + j < n) begin
          kexp[j] = 1'b1;
          wexp[8*j +: 8] = pat(8 * b + j, seed);
        end
      end
      chk(st_valid == 1'b1, {tag, " R4 valid during stream"}, DW'(st_valid), DW'(1));
      chk(st_data == wexp, {tag, " R4 word bytes"}, DW'(st_data), DW'(wexp));
      chk(st_keep == kexp, {tag, " R5 byte enables"}, DW'(st_keep), DW'(kexp));
      chk(st_last == (b == nw - 1), {tag, " R6 last flag"}, DW'(st_last), DW'(b == nw - 1));
      if (c > 0) chk(par_valid == 1'b0, {tag, " R3 R9 no extra pulse"}, DW'(par_valid), '0);
      rdy = !(stall && (c % 3 == 1));
      st_ready = rdy;
      if (inject && c == 1) begin
        done = 1'b1; digest = make_dig(seed + 50); alg = 3'd4; req = 32'd9;
      end
      @(negedge clk);
      done = 1'b0;
      if (rdy) b++;
      c++;
    end
    st_ready = 1'b0;
    chk(in_ready == 1'b1, {tag, " R8 ready high after final beat"}, DW'(in_ready), DW'(1));
    chk(st_valid == 1'b0, {tag, " R6 stream idle after final beat"}, DW'(st_valid), '0);
    chk(st_last == 1'b0, {tag, " R6 last low when idle"}, DW'(st_last), '0);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R8 reset ready", DW'(in_ready), DW'(1));
    chk(par_valid == 1'b0, "R3 reset pulse", DW'(par_valid), '0);
    chk(st_valid == 1'b0, "R6 reset stream", DW'(st_valid), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R8 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_job("fix224",   0, 0,   1, 1'b0, 1'b0);
    run_job("fix256",   1, 0,   2, 1'b0, 1'b0);
    run_job("fix384",   2, 0,   3, 1'b1, 1'b0);
    run_job("fix512",   3, 77,  4, 1'b1, 1'b0);
    run_job("xof128full", 4, 168, 5, 1'b0, 1'b0);
    run_job("xof128clamp", 4, 300, 6, 1'b1, 1'b0);
    run_job("xof128short", 4, 13, 7, 1'b0, 1'b0);
    run_job("xof256clamp", 5, 200, 8, 1'b0, 1'b0);
    run_job("xof256zero", 5, 0,   9, 1'b0, 1'b0);
    run_job("R9ignore",  3, 0,  10, 1'b0, 1'b1);
    run_job("R7stall",   1, 0,  11, 1'b1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule